// File: doc/BRIEF.md
# Remote Update Configuration Controller

This block decides which stored configuration image a reconfigurable device loads, and it watches a newly loaded application image with a user watchdog. After power-up it always asks for the protected factory image on page 0. The factory image then programs a control register with the page of the next application, a watchdog enable and a timeout. It then issues a launch command. The block requests that page and waits for the loader to report completion or failure. While the application runs, the application must keep kicking the watchdog.

If the application load fails, or the watchdog expires, the controller falls back to the factory page. It records why it fell back and which page failed. The bitstream transfer, flash programming and reception of new image data happen outside this block. It only sequences page selection and fallback.

Top module: `rupd_ctrl`

## Requirements
- R1: While reset is asserted, load_req and img_running are 0 and the status reads cause 0 (none) with failed page 0. After reset the first load request targets page 0.
- R2: A control register write whose page field is 0 is rejected as a whole. Page, enable and timeout all keep their previous values.
- R3: Control writes and the launch command take effect only while the factory image runs. A launch while the stored page is still 0 (no write accepted since reset) is ignored. Otherwise a launch causes a load request for the stored page on the next cycle.
- R4: load_req stays high until load_done or load_err arrives; load_err wins if both are high. When load_done is accepted, img_running rises on the next cycle, and img_page shows the running page.
- R5: In application mode with the watchdog enabled and timeout T, the counter starts at 0 in the first application cycle. With no kick the application runs T+1 cycles and then falls back. The status then reads cause 2 (watchdog) with the application's page, and page 0 is requested again.
- R6: A kick in application mode restarts the count from 0. A kick in the same cycle the count equals T counts as a restart, not as an expiry.
- R7: An error while loading an application leads to a fallback. The status reads cause 1 (load error) with that page, and a request for page 0 follows two cycles after the error.
- R8: While the factory image is loading or running, the watchdog is off and wd_active is 0, whatever the enable bit holds. The factory image is never timed out.
- R9: With the enable bit clear, an application runs indefinitely without kicks.
- R10: Status is not cleared by reads or by later successful loads. Only the next fallback overwrites it.
- R11: A load error while loading the factory page leaves the status unchanged and keeps requesting page 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous assert |
| cfg_we | input | 1 | Control register write strobe |
| cfg_page | input | PAGE_W | Next application page to write |
| cfg_wd_en | input | 1 | Watchdog enable to write |
| cfg_tmo | input | TMO_W | Watchdog timeout to write, in clock cycles |
| cfg_go | input | 1 | Launch the stored application page |
| load_req | output | 1 | Request to load the page on img_page |
| img_page | output | PAGE_W | Page being loaded or running |
| load_done | input | 1 | Loader reports successful load |
| load_err | input | 1 | Loader reports a failed load |
| wd_kick | input | 1 | Watchdog restart from the application |
| img_running | output | 1 | A configuration is in user mode |
| wd_active | output | 1 | Watchdog is counting |
| stat_cause | output | 2 | Last fallback cause: 0 none, 1 load error, 2 watchdog |
| stat_fail_page | output | PAGE_W | Page that caused the last fallback |

## Verification
The bench builds the block with its default widths: 3-bit pages and 12-bit timeouts. This makes every nonzero page reachable as a launch target, and it lets the largest timeout of 4095 be run to expiry in full. Random timeouts stay small so that many launch, kick and fallback sequences fit in one run. These are checked against a cycle model of the counter in the bench. Directed cases cover kicks that land exactly on the expiry cycle, rejected page 0 writes, and a failing factory load.

// File: rtl/rupd_pkg.sv
package rupd_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP   = 3'd0,
    ST_LD_FAC  = 3'd1,
    ST_FAC_RUN = 3'd2,
    ST_LD_APP  = 3'd3,
    ST_APP_RUN = 3'd4,
    ST_FALLBK  = 3'd5
  } rupd_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LDERR = 2'd1,
    CAUSE_WDOG  = 2'd2
  } rupd_cause_e;

endpackage

// File: rtl/rupd_fsm.sv
module rupd_fsm
  import rupd_pkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PAGE_W-1:0] ctrl_page,
  input  logic              load_done,
  input  logic              load_err,
  input  logic              wd_expire,
  output rupd_state_e       st
);

  rupd_state_e st_nxt;

  always_comb begin
    st_nxt = st;
    case (st)
      ST_PWRUP:   st_nxt = ST_LD_FAC;
      ST_LD_FAC:  if (!load_err && load_done) st_nxt = ST_FAC_RUN;
      ST_FAC_RUN: if (go && (ctrl_page != '0)) st_nxt = ST_LD_APP;
      ST_LD_APP: begin
        if (load_err)       st_nxt = ST_FALLBK;
        else if (load_done) st_nxt = ST_APP_RUN;
      end
      ST_APP_RUN: if (wd_expire) st_nxt = ST_FALLBK;
      ST_FALLBK:  st_nxt = ST_LD_FAC;
      default:    st_nxt = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_PWRUP;
    else        st <= st_nxt;
  end

  AST_PWRUP_TO_FACTORY: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_PWRUP |=> st == ST_LD_FAC);  // R1
  AST_EXPIRE_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> st == ST_FALLBK);  // R5
  AST_FALLBACK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_FALLBK |=> st == ST_LD_FAC);  // R7
  AST_FACTORY_ERR_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LD_FAC) && load_err |=> st == ST_LD_FAC);  // R11

endmodule

// File: rtl/rupd_wdog.sv
module rupd_wdog #(
  parameter int TMO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             app_run,
  input  logic             en,
  input  logic [TMO_W-1:0] tmo,
  input  logic             kick,
  output logic             expire,
  output logic             active
);

  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] cnt_nxt;
  logic             cnt_ce;

  assign active = app_run & en;
  assign expire = active & (cnt == tmo) & ~kick;

  always_comb begin
    cnt_ce  = 1'b1;
    cnt_nxt = '0;
    if (active && !kick) begin
      if (cnt != tmo) cnt_nxt = cnt + 1'b1;
      else begin
        cnt_nxt = cnt;
        cnt_ce  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_ce) cnt <= cnt_nxt;
  end

  AST_CNT_HELD_OUTSIDE_APP: assert property (@(posedge clk) disable iff (!rst_n)
    !app_run |=> cnt == '0);  // R8
  AST_KICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    active && kick |=> cnt == '0);  // R6

endmodule

// File: rtl/rupd_regs.sv
module rupd_regs
  import rupd_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int TMO_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rupd_state_e       st,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_wd_en,
  input  logic [TMO_W-1:0]  cfg_tmo,
  input  logic              load_err,
  input  logic              wd_expire,
  output logic [PAGE_W-1:0] ctrl_page,
  output logic              ctrl_wd_en,
  output logic [TMO_W-1:0]  ctrl_tmo,
  output logic [1:0]        stat_cause,
  output logic [PAGE_W-1:0] stat_fail_page
);

  logic wr_ok;
  logic lderr_ev;
  logic stat_ce;
  logic [1:0] cause_nxt;

  assign wr_ok    = cfg_we && (st == ST_FAC_RUN) && (cfg_page != '0);
  assign lderr_ev = (st == ST_LD_APP) && load_err;
  assign stat_ce  = lderr_ev | wd_expire;

  always_comb begin
    cause_nxt = stat_cause;
    if (lderr_ev)       cause_nxt = CAUSE_LDERR;
    else if (wd_expire) cause_nxt = CAUSE_WDOG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_page  <= '0;
      ctrl_wd_en <= 1'b0;
      ctrl_tmo   <= '0;
    end else if (wr_ok) begin
      ctrl_page  <= cfg_page;
      ctrl_wd_en <= cfg_wd_en;
      ctrl_tmo   <= cfg_tmo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_cause     <= CAUSE_NONE;
      stat_fail_page <= '0;
    end else if (stat_ce) begin
      stat_cause     <= cause_nxt;
      stat_fail_page <= ctrl_page;
    end
  end

  AST_PAGE0_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_page == '0) |=> $stable(ctrl_page) && $stable(ctrl_tmo) && $stable(ctrl_wd_en));  // R2
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(lderr_ev || wd_expire) |=> $stable(stat_cause) && $stable(stat_fail_page));  // R10
  AST_WDOG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> stat_cause == CAUSE_WDOG);  // R5
  AST_LDERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    lderr_ev |=> stat_cause == CAUSE_LDERR);  // R7

endmodule

// File: rtl/rupd_ctrl.sv
module rupd_ctrl
  import rupd_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter int TMO_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_wd_en,
  input  logic [TMO_W-1:0]  cfg_tmo,
  input  logic              cfg_go,
  output logic              load_req,
  output logic [PAGE_W-1:0] img_page,
  input  logic              load_done,
  input  logic              load_err,
  input  logic              wd_kick,
  output logic              img_running,
  output logic              wd_active,
  output logic [1:0]        stat_cause,
  output logic [PAGE_W-1:0] stat_fail_page
);

  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync;
  logic              rst_n_s;
  rupd_state_e       st;
  logic [PAGE_W-1:0] ctrl_page;
  logic              ctrl_wd_en;
  logic [TMO_W-1:0]  ctrl_tmo;
  logic              wd_expire;
  logic              app_run;
  logic              app_side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_s = rst_sync[SYNC_N-1];

  assign app_run     = (st == ST_APP_RUN);
  assign app_side    = (st == ST_LD_APP) || app_run;
  assign load_req    = (st == ST_LD_FAC) || (st == ST_LD_APP);
  assign img_page    = app_side ? ctrl_page : '0;
  assign img_running = (st == ST_FAC_RUN) || app_run;

  rupd_fsm #(.PAGE_W(PAGE_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .go        (cfg_go),
    .ctrl_page (ctrl_page),
    .load_done (load_done),
    .load_err  (load_err),
    .wd_expire (wd_expire),
    .st        (st)
  );

  rupd_wdog #(.TMO_W(TMO_W)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .app_run (app_run),
    .en      (ctrl_wd_en),
    .tmo     (ctrl_tmo),
    .kick    (wd_kick),
    .expire  (wd_expire),
    .active  (wd_active)
  );

  rupd_regs #(.PAGE_W(PAGE_W), .TMO_W(TMO_W)) u_regs (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .st             (st),
    .cfg_we         (cfg_we),
    .cfg_page       (cfg_page),
    .cfg_wd_en      (cfg_wd_en),
    .cfg_tmo        (cfg_tmo),
    .load_err       (load_err),
    .wd_expire      (wd_expire),
    .ctrl_page      (ctrl_page),
    .ctrl_wd_en     (ctrl_wd_en),
    .ctrl_tmo       (ctrl_tmo),
    .stat_cause     (stat_cause),
    .stat_fail_page (stat_fail_page)
  );

  AST_FACTORY_NO_WDOG: assert property (@(posedge clk) disable iff (!rst_n_s)
    !app_side |-> !wd_active && !wd_expire);  // R8
  AST_FACTORY_PAGE0: assert property (@(posedge clk) disable iff (!rst_n_s)
    load_req && !app_side |-> img_page == '0);  // R1

endmodule

// File: tb/rupd_ctrl_tb.sv
module rupd_ctrl_tb;

  localparam int PAGE_W = 3;
  localparam int TMO_W  = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we, cfg_wd_en, cfg_go;
  logic [PAGE_W-1:0] cfg_page;
  logic [TMO_W-1:0]  cfg_tmo;
  logic              load_req, load_done, load_err, wd_kick;
  logic [PAGE_W-1:0] img_page, stat_fail_page;
  logic              img_running, wd_active;
  logic [1:0]        stat_cause;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  int m_page, m_en, m_tmo, m_cause, m_fpage;

  always #5 clk = ~clk;

  rupd_ctrl #(.PAGE_W(PAGE_W), .TMO_W(TMO_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
    .cfg_wd_en(cfg_wd_en), .cfg_tmo(cfg_tmo), .cfg_go(cfg_go),
    .load_req(load_req), .img_page(img_page), .load_done(load_done),
    .load_err(load_err), .wd_kick(wd_kick), .img_running(img_running),
    .wd_active(wd_active), .stat_cause(stat_cause), .stat_fail_page(stat_fail_page)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung act=%0d exp=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic bit exp_expire(int cnt, int tmo, int en, bit kick);
    return (en != 0) && (cnt == tmo) && !kick;
  endfunction

  function automatic bit write_taken(int page);
    return page != 0;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick();
    chk(load_req == 0, "R1 reset load_req", load_req, 0);
    chk(img_running == 0, "R1 reset running", img_running, 0);
    chk(stat_cause == 0, "R1 reset cause", stat_cause, 0);
    chk(stat_fail_page == 0, "R1 reset fail page", stat_fail_page, 0);
    tick();
    rst_n = 1'b1;
    m_page = 0; m_en = 0; m_tmo = 0; m_cause = 0; m_fpage = 0;
  endtask

  task automatic wait_req();
    bit seen = 0;
    for (int i = 0; i < 8 && !seen; i++) begin
      if (load_req) seen = 1;
      else tick();
    end
    chk(seen, "R4 load request seen", seen, 1);
  endtask

  task automatic boot_factory();
    wait_req();
    chk(img_page == 0, "R1 factory page", img_page, 0);
    load_done = 1'b1;
    tick();
    load_done = 1'b0;
    chk(img_running == 1, "R4 factory running", img_running, 1);
    chk(load_req == 0, "R4 request dropped", load_req, 0);
    chk(wd_active == 0, "R8 watchdog off in factory", wd_active, 0);
  endtask

  task automatic write_cfg(int page, int en, int tmo);
    cfg_we = 1'b1; cfg_page = page[PAGE_W-1:0];
    cfg_wd_en = en[0]; cfg_tmo = tmo[TMO_W-1:0];
    tick();
    cfg_we = 1'b0;
    if (write_taken(page)) begin
      m_page = page; m_en = en; m_tmo = tmo;
    end
  endtask

  task automatic launch();
    cfg_go = 1'b1;
    tick();
    cfg_go = 1'b0;
    chk(load_req == 1, "R3 launch requests", load_req, 1);
    chk(img_page == m_page[PAGE_W-1:0], "R3 launch page", img_page, m_page);
  endtask

  // mode 0: no kicks, 1: random kicks, 2: kick only in the expiry cycle
  task automatic app_phase(int mode, int maxk, bit stray_wr);
    int  mc = 0;
    bit  done = 0;
    bit  k, e;
    load_done = 1'b1;
    tick();
    load_done = 1'b0;
    chk(stat_cause == m_cause, "R10 cause kept over load", stat_cause, m_cause);
    chk(img_page == m_page[PAGE_W-1:0], "R4 running page", img_page, m_page);
    for (int c = 0; !done; c++) begin
      if (img_running != 1) begin
        chk(0, "R6 app still running", img_running, 1);
        done = 1;
      end else begin
        chk(wd_active == m_en[0], "R5 watchdog active", wd_active, m_en);
        k = 0;
        if (c < maxk) begin
          if (mode == 1) k = ($urandom % 10) < 7;
          if (mode == 2) k = (mc == m_tmo);
        end
        wd_kick = k;
        if (stray_wr && c == 0) begin
          cfg_we = 1'b1; cfg_page = 3'd6; cfg_wd_en = 1'b0; cfg_tmo = 12'd99;
        end
        e = exp_expire(mc, m_tmo, m_en, k);
        tick();
        wd_kick = 1'b0; cfg_we = 1'b0;
        if (e) begin
          chk(img_running == 0, "R5 fallback after expiry", img_running, 0);
          chk(stat_cause == 2, "R5 cause watchdog", stat_cause, 2);
          chk(stat_fail_page == m_page[PAGE_W-1:0], "R5 failed page", stat_fail_page, m_page);
          m_cause = 2; m_fpage = m_page;
          tick();
          chk(load_req == 1 && img_page == 0, "R5 reload page 0", img_page, 0);
          done = 1;
        end else begin
          mc = k ? 0 : mc + 1;
          if (m_en == 0 && c >= 300) begin
            chk(img_running == 1, "R9 disabled watchdog runs on", img_running, 1);
            done = 1;
          end
        end
      end
    end
  endtask

  task automatic app_load_error();
    load_err = 1'b1;
    tick();
    load_err = 1'b0;
    chk(stat_cause == 1, "R7 cause load error", stat_cause, 1);
    chk(stat_fail_page == m_page[PAGE_W-1:0], "R7 failed page", stat_fail_page, m_page);
    chk(img_running == 0, "R7 not running", img_running, 0);
    m_cause = 1; m_fpage = m_page;
    tick();
    chk(load_req == 1 && img_page == 0, "R7 reload page 0", img_page, 0);
  endtask

  initial begin
    int seed = $urandom(32'h5eed);
    rst_n = 1'b0;
    cfg_we = 0; cfg_wd_en = 0; cfg_go = 0; cfg_page = '0; cfg_tmo = '0;
    load_done = 0; load_err = 0; wd_kick = 0;
    seed = 0;
    do_reset();

    // R11: factory load error retries page 0
    wait_req();
    load_err = 1'b1;
    tick();
    load_err = 1'b0;
    chk(load_req == 1 && img_page == 0, "R11 factory retry", img_page, 0);
    chk(stat_cause == 0, "R11 status untouched", stat_cause, 0);
    boot_factory();

    // R3: launch with no valid page stored is ignored
    cfg_go = 1'b1; tick(); cfg_go = 1'b0;
    tick(); tick();
    chk(load_req == 0 && img_running == 1, "R3 launch ignored on page 0", load_req, 0);

    // R2: page-0 writes rejected whole
    write_cfg(0, 1, 7);
    write_cfg(5, 1, 3);
    write_cfg(0, 0, 9);
    // R8: factory never times out
    for (int i = 0; i < 20; i++) begin
      wd_kick = 1'b0;
      tick();
      chk(img_running && !load_req && !wd_active, "R8 factory untimed", wd_active, 0);
    end
    launch();
    app_phase(0, 0, 0);  // R5 with T=3 proves timeout kept (R2)
    boot_factory();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(stat_cause == 2 && stat_fail_page == 5, "R10 status persists", stat_cause, 2);
    end

    // R7 load error
    write_cfg(2, 1, 4);
    launch();
    app_load_error();
    boot_factory();

    // R6 kicks in the expiry cycle
    launch();
    app_phase(2, 30, 0);
    boot_factory();

    // R5 largest timeout
    write_cfg(7, 1, 4095);
    launch();
    app_phase(0, 0, 0);
    boot_factory();

    // random mix
    for (int it = 0; it < 25; it++) begin
      int p = $urandom % 8;
      int t = $urandom % 24;
      write_cfg(p, 1, t);
      if (m_page == 0) write_cfg(1 + ($urandom % 7), 1, t);
      launch();
      if (($urandom % 4) == 0) app_load_error();
      else app_phase(1 + ($urandom % 2), $urandom % 60, ($urandom % 3) == 0);
      boot_factory();
    end

    // R9 disabled watchdog
    write_cfg(3, 0, 2);
    launch();
    app_phase(0, 0, 0);
    do_reset();
    boot_factory();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule